// File: doc/BRIEF.md
# Prototype Correlator With Global Max

The block scores a set of stored prototype patches against pooled feature maps. A feature map exists for every orientation at every scale. For one prototype, position and scale, the response is the sum over orientations of a square 2D correlation between the prototype's patch for that orientation and the feature window at that position. The block keeps only the largest response of each prototype over all positions and scales. It emits one maximum per prototype and never writes out a per-position map.

A parallel array of multipliers, one lane per patch coefficient, computes a whole window in one cycle. The window sums of one scale are added across orientations in an on-chip scratchpad, one entry per position. When the last orientation of a position completes, its finished response goes straight into a running maximum. Feature words and prototype coefficients come in through plain synchronous read ports. The side length of each scale's square map comes from a combinational lookup port. A start pulse captures the prototype, scale and orientation counts, and the block then runs to completion.

Top module: `proto_corr_max`

## Requirements
- R1: A response is the sum, over orientations 0..N-1, of the window sums at one scale and position. Lane k = ky*PDIM+kx uses coefficient bits [32k+31:32k] of the coefficient word at address proto*MAX_ORIENTS+orient. It also uses the feature word at address ((scale*MAX_ORIENTS+orient)*MAX_DIM+y+ky)*MAX_DIM+x+kx.
- R2: Each prototype produces exactly one result: the largest response over all positions of all configured scales.
- R3: Values are signed two's-complement with 24 fraction bits. Each product is shifted right arithmetically by 24, so it is truncated toward minus infinity.
- R4: A window sum, and the sum across orientations, each clamp to 0x7FFFFFFF or 0x80000000 instead of wrapping.
- R5: The running maximum restarts from 0x80000000 for each prototype, so a result never depends on an earlier prototype.
- R6: Orientation 0 overwrites a scratchpad entry rather than adding to it. This stays correct when a scale has one position, so consecutive orientations hit the same entry on back-to-back cycles.
- R7: res_valid_o is high for one cycle per result and carries the prototype index in res_proto_o. Results come in ascending index order.
- R8: With E = orientations × the sum over scales of (side-PDIM+1)², the result of prototype p is valid (p+1)*E+2 cycles after the clock edge that accepts start_i.
- R9: The counts are captured when start is accepted. A start_i pulse or a change to the count inputs while busy_o is high has no effect.
- R10: After reset, busy_o and res_valid_o are low.
- R11: scale_idx_o selects the scale whose side length is read on scale_dim_i. That scale has side-PDIM+1 positions per axis.
- R12: Both memory ports have one cycle of read latency. Data for the addresses presented while rd_en_o is high is expected in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a run (accepted only when idle) |
| cfg_num_protos_i | input | 14 | Number of prototypes (1..MAX_PROTOS) |
| cfg_num_scales_i | input | 5 | Number of scales (1..MAX_SCALES) |
| cfg_num_orients_i | input | 5 | Number of orientations (1..MAX_ORIENTS) |
| scale_idx_o | output | 4 | Scale whose side length is requested |
| scale_dim_i | input | 5 | Side length of that scale's square map |
| rd_en_o | output | 1 | Read strobe for both memory ports |
| feat_addr_o | output | 256 | One feature word address per lane |
| feat_data_i | input | 512 | One feature word per lane |
| coef_addr_o | output | 17 | Coefficient window address |
| coef_data_i | input | 512 | All lane coefficients of one window |
| busy_o | output | 1 | Run or pipeline in progress |
| res_valid_o | output | 1 | Result strobe |
| res_proto_o | output | 13 | Prototype index of the result |
| res_max_o | output | 32 | Maximum response of that prototype |

## Verification
The path from an address to a result has three registers: the memory read, the window sum and the pooling stage. So the last element of prototype p yields its result exactly (p+1)*E+2 cycles after the accepting edge. The bench counts cycles from that edge. It samples on the falling edge and compares the cycle in which each result appears against that formula, as well as the index and value. The end of a run is taken from busy_o falling, so the number of results is also checked, including when a start pulse and changed counts arrive mid-run.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
  localparam int DW   = 32;
  localparam int FRAC = 24;
  localparam logic signed [DW-1:0] MOST_POS = 32'sh7FFF_FFFF;
  localparam logic signed [DW-1:0] MOST_NEG = 32'sh8000_0000;

  typedef struct packed {
    logic first;      // orientation 0
    logic last;       // final orientation
    logic max_init;   // first finished response of a prototype
    logic proto_end;  // final element of a prototype
  } elem_flags_t;

  function automatic logic signed [DW-1:0] sat_dw(input logic signed [63:0] v);
    if (v > 64'sd2147483647) return MOST_POS;
    else if (v < -64'sd2147483648) return MOST_NEG;
    else return v[DW-1:0];
  endfunction
endpackage

// File: rtl/pcx_seq.sv
module pcx_seq import pcx_pkg::*; #(
  parameter int PDIM        = 4,
  parameter int MAX_DIM     = 16,
  parameter int MAX_ORIENTS = 16,
  parameter int MAX_SCALES  = 16,
  parameter int MAX_PROTOS  = 8192,
  localparam int LANES    = PDIM * PDIM,
  localparam int NPOS_MAX = MAX_DIM - PDIM + 1,
  localparam int XW       = $clog2(MAX_DIM),
  localparam int DIM_W    = $clog2(MAX_DIM + 1),
  localparam int OR_W     = $clog2(MAX_ORIENTS),
  localparam int NOR_W    = $clog2(MAX_ORIENTS + 1),
  localparam int SC_W     = $clog2(MAX_SCALES),
  localparam int NSC_W    = $clog2(MAX_SCALES + 1),
  localparam int PR_W     = $clog2(MAX_PROTOS),
  localparam int NPR_W    = $clog2(MAX_PROTOS + 1),
  localparam int FA_W     = SC_W + OR_W + 2 * XW,
  localparam int CA_W     = PR_W + OR_W,
  localparam int PIDX_W   = $clog2(NPOS_MAX * NPOS_MAX)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  pipe_busy_i,
  input  logic [NPR_W-1:0]      cfg_num_protos_i,
  input  logic [NSC_W-1:0]      cfg_num_scales_i,
  input  logic [NOR_W-1:0]      cfg_num_orients_i,
  output logic [SC_W-1:0]       scale_idx_o,
  input  logic [DIM_W-1:0]      scale_dim_i,
  output logic                  issue_o,
  output elem_flags_t           flags_o,
  output logic [PIDX_W-1:0]     pos_o,
  output logic [PR_W-1:0]       proto_o,
  output logic [LANES*FA_W-1:0] feat_addr_o,
  output logic [CA_W-1:0]       coef_addr_o
);
  logic [NPR_W-1:0] n_pr_q;
  logic [NSC_W-1:0] n_sc_q;
  logic [NOR_W-1:0] n_or_q;
  logic [PR_W-1:0]  proto_q;
  logic [SC_W-1:0]  scale_q;
  logic [OR_W-1:0]  orient_q;
  logic [XW-1:0]    y_q, x_q;
  logic             running_q;
  logic             accept;
  logic [DIM_W-1:0] npos;
  logic             x_wrap, y_wrap, o_wrap, s_wrap, p_wrap;

  assign npos   = scale_dim_i - DIM_W'(PDIM - 1);
  assign x_wrap = DIM_W'(x_q) == npos - DIM_W'(1);
  assign y_wrap = DIM_W'(y_q) == npos - DIM_W'(1);
  assign o_wrap = NOR_W'(orient_q) == n_or_q - NOR_W'(1);
  assign s_wrap = NSC_W'(scale_q) == n_sc_q - NSC_W'(1);
  assign p_wrap = NPR_W'(proto_q) == n_pr_q - NPR_W'(1);

  assign accept = start_i && !running_q && !pipe_busy_i &&
                  cfg_num_protos_i != '0 && cfg_num_scales_i != '0 &&
                  cfg_num_orients_i != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_pr_q <= '0; n_sc_q <= '0; n_or_q <= '0;
      proto_q <= '0; scale_q <= '0; orient_q <= '0; y_q <= '0; x_q <= '0;
      running_q <= 1'b0;
    end else if (accept) begin
      n_pr_q <= cfg_num_protos_i;
      n_sc_q <= cfg_num_scales_i;
      n_or_q <= cfg_num_orients_i;
      proto_q <= '0; scale_q <= '0; orient_q <= '0; y_q <= '0; x_q <= '0;
      running_q <= 1'b1;
    end else if (running_q) begin
      // loop nest: proto > scale > orientation > row > column
      if (!x_wrap) x_q <= x_q + XW'(1);
      else begin
        x_q <= '0;
        if (!y_wrap) y_q <= y_q + XW'(1);
        else begin
          y_q <= '0;
          if (!o_wrap) orient_q <= orient_q + OR_W'(1);
          else begin
            orient_q <= '0;
            if (!s_wrap) scale_q <= scale_q + SC_W'(1);
            else begin
              scale_q <= '0;
              if (!p_wrap) proto_q <= proto_q + PR_W'(1);
              else running_q <= 1'b0;
            end
          end
        end
      end
    end
  end

  assign scale_idx_o       = scale_q;
  assign issue_o           = running_q;
  assign proto_o           = proto_q;
  assign flags_o.first     = orient_q == '0;
  assign flags_o.last      = o_wrap;
  assign flags_o.max_init  = scale_q == '0 && y_q == '0 && x_q == '0 && o_wrap;
  assign flags_o.proto_end = p_wrap_end();
  assign pos_o  = PIDX_W'(y_q) * PIDX_W'(NPOS_MAX) + PIDX_W'(x_q);
  assign coef_addr_o = CA_W'(proto_q) * CA_W'(MAX_ORIENTS) + CA_W'(orient_q);

  function automatic logic p_wrap_end();
    return s_wrap && o_wrap && y_wrap && x_wrap;
  endfunction

  for (genvar k = 0; k < LANES; k++) begin : g_lane_addr
    localparam int KY = k / PDIM;
    localparam int KX = k % PDIM;
    assign feat_addr_o[k*FA_W +: FA_W] =
      ((FA_W'(scale_q) * FA_W'(MAX_ORIENTS) + FA_W'(orient_q)) * FA_W'(MAX_DIM)
       + FA_W'(y_q) + FA_W'(KY)) * FA_W'(MAX_DIM) + FA_W'(x_q) + FA_W'(KX);
  end

  p_pos_bound_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_q |-> (DIM_W'(x_q) < npos && DIM_W'(y_q) < npos));
  p_orient_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_q |-> NOR_W'(orient_q) < n_or_q);
  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (running_q || pipe_busy_i)) |=>
      ($stable(n_pr_q) && $stable(n_sc_q) && $stable(n_or_q)));
endmodule

// File: rtl/pcx_mac.sv
module pcx_mac import pcx_pkg::*; #(
  parameter int LANES = 16
) (
  input  logic [LANES*DW-1:0]  feat_i,
  input  logic [LANES*DW-1:0]  coef_i,
  output logic signed [DW-1:0] win_o
);
  logic signed [63:0] prod [LANES];
  logic signed [63:0] shf  [LANES];
  logic signed [63:0] total;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign prod[k] = 64'($signed(feat_i[k*DW +: DW])) * 64'($signed(coef_i[k*DW +: DW]));
    assign shf[k]  = prod[k] >>> FRAC;  // floor truncation back to Q7.24
  end

  always_comb begin
    total = '0;
    for (int k = 0; k < LANES; k++) total = total + shf[k];
  end

  assign win_o = sat_dw(total);
endmodule

// File: rtl/pcx_pool.sv
module pcx_pool import pcx_pkg::*; #(
  parameter int ENTRIES = 169,
  parameter int PR_W    = 13,
  localparam int PIDX_W = $clog2(ENTRIES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 v_i,
  input  elem_flags_t          flags_i,
  input  logic [PIDX_W-1:0]    pos_i,
  input  logic [PR_W-1:0]      proto_i,
  input  logic signed [DW-1:0] win_i,
  output logic                 res_valid_o,
  output logic [PR_W-1:0]      res_proto_o,
  output logic [DW-1:0]        res_max_o
);
  logic signed [DW-1:0] spad_q [ENTRIES];
  logic signed [DW-1:0] max_q, res_max_q;
  logic [PR_W-1:0]      res_proto_q;
  logic                 res_valid_q;
  logic signed [DW-1:0] entry, acc, base, cand;

  assign entry = spad_q[pos_i];
  assign acc   = flags_i.first ? win_i : sat_dw(64'(entry) + 64'(win_i));
  assign base  = flags_i.max_init ? MOST_NEG : max_q;
  assign cand  = (acc > base) ? acc : base;

  // scratchpad: combinational read, write at the edge, so back-to-back hits see fresh data
  always_ff @(posedge clk_i) begin
    if (v_i && !flags_i.last) spad_q[pos_i] <= acc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      max_q       <= MOST_NEG;
      res_valid_q <= 1'b0;
      res_max_q   <= '0;
      res_proto_q <= '0;
    end else begin
      if (v_i && flags_i.last) max_q <= cand;
      res_valid_q <= v_i && flags_i.proto_end;
      if (v_i && flags_i.proto_end) begin
        res_max_q   <= cand;
        res_proto_q <= proto_i;
      end
    end
  end

  assign res_valid_o = res_valid_q;
  assign res_proto_o = res_proto_q;
  assign res_max_o   = res_max_q;

  p_max_mono_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_i && flags_i.last && !flags_i.max_init) |=> max_q >= $past(max_q));
  p_no_wrap_pos_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_i && !flags_i.first && entry > 0 && win_i > 0) |-> acc > 0);
  p_no_wrap_neg_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_i && !flags_i.first && entry < 0 && win_i < 0) |-> acc < 0);
endmodule

// File: rtl/proto_corr_max.sv
module proto_corr_max import pcx_pkg::*; #(
  parameter int PDIM        = 4,
  parameter int MAX_DIM     = 16,
  parameter int MAX_ORIENTS = 16,
  parameter int MAX_SCALES  = 16,
  parameter int MAX_PROTOS  = 8192,
  localparam int LANES    = PDIM * PDIM,
  localparam int NPOS_MAX = MAX_DIM - PDIM + 1,
  localparam int ENTRIES  = NPOS_MAX * NPOS_MAX,
  localparam int PIDX_W   = $clog2(ENTRIES),
  localparam int DIM_W    = $clog2(MAX_DIM + 1),
  localparam int SC_W     = $clog2(MAX_SCALES),
  localparam int PR_W     = $clog2(MAX_PROTOS),
  localparam int FA_W     = SC_W + $clog2(MAX_ORIENTS) + 2 * $clog2(MAX_DIM),
  localparam int CA_W     = PR_W + $clog2(MAX_ORIENTS)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              start_i,
  input  logic [$clog2(MAX_PROTOS+1)-1:0]   cfg_num_protos_i,
  input  logic [$clog2(MAX_SCALES+1)-1:0]   cfg_num_scales_i,
  input  logic [$clog2(MAX_ORIENTS+1)-1:0]  cfg_num_orients_i,
  output logic [SC_W-1:0]                   scale_idx_o,
  input  logic [DIM_W-1:0]                  scale_dim_i,
  output logic                              rd_en_o,
  output logic [LANES*FA_W-1:0]             feat_addr_o,
  input  logic [LANES*DW-1:0]               feat_data_i,
  output logic [CA_W-1:0]                   coef_addr_o,
  input  logic [LANES*DW-1:0]               coef_data_i,
  output logic                              busy_o,
  output logic                              res_valid_o,
  output logic [PR_W-1:0]                   res_proto_o,
  output logic [DW-1:0]                     res_max_o
);
  logic                 issue;
  elem_flags_t          flags0, flags1_q, flags2_q;
  logic [PIDX_W-1:0]    pos0, pos1_q, pos2_q;
  logic [PR_W-1:0]      proto0, proto1_q, proto2_q;
  logic                 v1_q, v2_q;
  logic signed [DW-1:0] win, win2_q;

  pcx_seq #(
    .PDIM(PDIM), .MAX_DIM(MAX_DIM), .MAX_ORIENTS(MAX_ORIENTS),
    .MAX_SCALES(MAX_SCALES), .MAX_PROTOS(MAX_PROTOS)
  ) i_seq (
    .clk_i, .rst_ni, .start_i,
    .pipe_busy_i      (v1_q || v2_q),
    .cfg_num_protos_i, .cfg_num_scales_i, .cfg_num_orients_i,
    .scale_idx_o, .scale_dim_i,
    .issue_o          (issue),
    .flags_o          (flags0),
    .pos_o            (pos0),
    .proto_o          (proto0),
    .feat_addr_o, .coef_addr_o
  );

  pcx_mac #(.LANES(LANES)) i_mac (
    .feat_i (feat_data_i),
    .coef_i (coef_data_i),
    .win_o  (win)
  );

  // stage 1: memory data returns; stage 2: window sum registered
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0; flags1_q <= '0; pos1_q <= '0; proto1_q <= '0;
      v2_q <= 1'b0; flags2_q <= '0; pos2_q <= '0; proto2_q <= '0; win2_q <= '0;
    end else begin
      v1_q <= issue; flags1_q <= flags0; pos1_q <= pos0; proto1_q <= proto0;
      v2_q <= v1_q;  flags2_q <= flags1_q; pos2_q <= pos1_q; proto2_q <= proto1_q;
      win2_q <= win;
    end
  end

  pcx_pool #(.ENTRIES(ENTRIES), .PR_W(PR_W)) i_pool (
    .clk_i, .rst_ni,
    .v_i     (v2_q),
    .flags_i (flags2_q),
    .pos_i   (pos2_q),
    .proto_i (proto2_q),
    .win_i   (win2_q),
    .res_valid_o, .res_proto_o, .res_max_o
  );

  assign rd_en_o = issue;
  assign busy_o  = issue || v1_q || v2_q;

  p_res_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |-> !res_valid_o);
endmodule

// File: tb/test_proto_corr_max.sv
module test_proto_corr_max;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [13:0] cfg_np = '0;
  logic [4:0]  cfg_ns = '0, cfg_no = '0;
  logic [3:0]  scale_idx;
  logic [4:0]  scale_dim;
  logic        rd_en, busy, res_valid;
  logic [255:0] feat_addr;
  logic [511:0] feat_data = '0, coef_data = '0;
  logic [16:0]  coef_addr;
  logic [12:0]  res_proto;
  logic [31:0]  res_max;

  logic [4:0] dims [16];
  int mode = 0, cyc = 0, start_cyc = 0, n_tests = 0, n_fail = 0;
  int res_cnt = 0;
  int got_proto [16], got_cyc [16];
  logic [31:0] got_max [16], exp_max [16];
  int exp_e = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  proto_corr_max i_proto_corr_max (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .cfg_num_protos_i(cfg_np), .cfg_num_scales_i(cfg_ns), .cfg_num_orients_i(cfg_no),
    .scale_idx_o(scale_idx), .scale_dim_i(scale_dim), .rd_en_o(rd_en),
    .feat_addr_o(feat_addr), .feat_data_i(feat_data),
    .coef_addr_o(coef_addr), .coef_data_i(coef_data),
    .busy_o(busy), .res_valid_o(res_valid), .res_proto_o(res_proto), .res_max_o(res_max)
  );

  assign scale_dim = dims[scale_idx];

  function automatic logic [31:0] feat_val(int m, int a);
    case (m)
      0: return 32'((((a * 37 + 11) % 201) - 100) <<< 16);
      1: return 32'h0100_0000;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] coef_val(int m, int ca, int lane);
    int p;
    p = ca / 16;
    case (m)
      0: return 32'((((ca * 13 + lane * 7) % 51) - 25) <<< 20);
      1: return (p == 0) ? 32'h4000_0000 : (p == 1) ? 32'hFF00_0000 : 32'h8000_0000;
      default: return (lane != 0) ? 32'h0 : (p == 0) ? 32'h0080_0000 : 32'h0180_0000;
    endcase
  endfunction

  // memory model, one cycle read latency (R12)
  always @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      feat_data[k*32 +: 32] <= feat_val(mode, int'(feat_addr[k*16 +: 16]));
      coef_data[k*32 +: 32] <= coef_val(mode, int'(coef_addr), k);
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (res_cnt < 16) begin
        got_proto[res_cnt] = int'(res_proto);
        got_max[res_cnt]   = res_max;
        got_cyc[res_cnt]   = cyc - start_cyc;
      end
      res_cnt++;
    end
  end

  function automatic longint sat(longint v);
    if (v > 64'sd2147483647) return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  task automatic model(int np, int ns, int no);
    exp_e = 0;
    for (int s = 0; s < ns; s++) exp_e += no * (dims[s] - 3) * (dims[s] - 3);
    for (int p = 0; p < np; p++) begin
      longint mx;
      mx = -64'sd2147483648;
      for (int s = 0; s < ns; s++) begin
        int np_s;
        np_s = dims[s] - 3;
        for (int y = 0; y < np_s; y++)
          for (int x = 0; x < np_s; x++) begin
            longint acc;
            acc = 0;
            for (int o = 0; o < no; o++) begin
              longint w;
              w = 0;
              for (int k = 0; k < LANES; k++) begin
                int fa;
                longint f, c;
                fa = ((s * 16 + o) * 16 + y + k / 4) * 16 + x + k % 4;
                f = longint'($signed(feat_val(mode, fa)));
                c = longint'($signed(coef_val(mode, p * 16 + o, k)));
                w += (f * c) >>> 24;
              end
              w = sat(w);
              acc = (o == 0) ? w : sat(acc + w);
            end
            if (acc > mx) mx = acc;
          end
      end
      exp_max[p] = 32'(mx);
    end
  endtask

  task automatic check(string req, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic run_case(string req, int np, int ns, int no, int m, bit poke);
    mode = m;
    model(np, ns, no);
    res_cnt = 0;
    cfg_np = 14'(np); cfg_ns = 5'(ns); cfg_no = 5'(no);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    start_cyc = cyc;
    if (poke) begin
      repeat (5) @(negedge clk);
      cfg_np = 14'd5; cfg_no = 5'd1;  // R9: must be ignored mid-run
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    check(poke ? "R9" : "R7", "result count", res_cnt, np);
    for (int p = 0; p < np && p < 16; p++) begin
      check("R7", "proto index", got_proto[p], p);
      check(req, "max value", got_max[p], exp_max[p]);
      check("R8", "result cycle", got_cyc[p], (p + 1) * exp_e + 2);
    end
  endtask

  task automatic t_reset;
    check("R10", "busy after reset", busy, 0);
    check("R10", "res_valid after reset", res_valid, 0);
  endtask

  // R1 R11 R12: two scales, three orientations, mid-run start poke
  task automatic t_basic;
    dims[0] = 5'd6; dims[1] = 5'd5;
    run_case("R1", 2, 2, 3, 0, 1'b1);
  endtask

  // R6: one position per scale, consecutive orientations hit the same entry
  task automatic t_single_pos;
    dims[0] = 5'd4;
    run_case("R6", 2, 1, 4, 0, 1'b0);
  endtask

  // R4 R5: positive clamp, then negative prototype, then negative clamp
  task automatic t_saturate;
    dims[0] = 5'd5;
    run_case("R5", 3, 1, 2, 1, 1'b0);
    check("R4", "positive clamp", got_max[0], 32'h7FFF_FFFF);
    check("R5", "max restart after positive proto", got_max[1], 32'hE000_0000);
    check("R4", "negative clamp", got_max[2], 32'h8000_0000);
  endtask

  // R3: -1 lsb times 0.5 floors to -1, times 1.5 floors to -2
  task automatic t_truncate;
    dims[0] = 5'd4;
    run_case("R3", 2, 1, 1, 2, 1'b0);
    check("R3", "floor of -0.5 lsb", got_max[0], 32'hFFFF_FFFF);
    check("R3", "floor of -1.5 lsb", got_max[1], 32'hFFFF_FFFE);
  endtask

  // R2: maximum over three scales of different size
  task automatic t_multi_scale;
    dims[0] = 5'd8; dims[1] = 5'd6; dims[2] = 5'd4;
    run_case("R2", 3, 3, 2, 0, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) dims[i] = 5'd4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_single_pos();
    t_saturate();
    t_truncate();
    t_multi_scale();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule